// File: doc/BRIEF.md
# SDRAM Refresh Scheduler with Host Arbitration

This block decides when an SDRAM device must be refreshed and keeps host traffic out of the way while that happens. A down-counting timer reloads from a programmable period value and raises a refresh request each time it runs out. The device produces its own refresh row address, so the block issues only two commands. It first sends a precharge-all. After the row-precharge time it sends an auto-refresh. It then holds the device for a programmable recovery time before going back to idle.

Host accesses are stalled rather than rejected. A host request sees a wait signal while a refresh is pending or running. A refresh that falls due during a host burst waits until that burst ends. From that point it has priority over any further host request. If a refresh falls due while the one before it has still not been started, the block records a missed refresh in a sticky status flag. The flag drives an interrupt through an enable bit and is cleared by reading the status register.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted, cmdPrecharge, cmdRefresh, hostWait, irq and both statusData bits are 0.
- R2: With a nonzero refresh period P and no host burst in the way, consecutive precharge-all commands are exactly P cycles apart.
- R3: Each auto-refresh command (cmdRefresh, a one-cycle pulse) comes exactly TRP cycles after the precharge-all pulse that starts the same refresh. The two commands are never asserted together.
- R4: After the auto-refresh, the sequencer stays busy for max(trfcCfg,1) further cycles. It is idle again in the following cycle. While it is busy, any host request sees hostWait=1.
- R5: While a refresh request is pending but not yet started, a host request sees hostWait=1. In all other idle cycles, hostWait=0.
- R6: While hostActive is 1 (host burst in flight), no refresh is started. The precharge-all comes in the cycle after the first cycle in which hostActive is 0 and a request is pending.
- R7: A period value of 0 stops the timer, drops any pending request, issues no new refresh and never flags an error.
- R8: When the timer expires while the previous request is still pending and is not being started in that cycle, statusData[0] (missed-refresh flag) becomes 1 in the next cycle. It stays 1 until it is read.
- R9: irq equals statusData[0] AND irqEn, with no added delay.
- R10: A cycle with statusRd=1 still shows the flag on statusData[0], and the flag reads 0 from the next cycle. A miss in the read cycle wins, and the flag stays 1.
- R11: statusData[1] is 1 whenever a refresh is pending or the sequencer is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodCfg | input | PERIOD_W | Cycles between refreshes; 0 disables |
| trfcCfg | input | TRFC_W | Busy cycles after auto-refresh (0 acts as 1) |
| irqEn | input | 1 | Interrupt enable |
| statusRd | input | 1 | Status register read strobe; clears the missed-refresh flag |
| statusData | output | 2 | Bit 0 missed-refresh flag, bit 1 refresh pending or running |
| irq | output | 1 | Missed-refresh interrupt |
| hostReq | input | 1 | Host requests an SDRAM access |
| hostActive | input | 1 | A granted host burst is in flight |
| hostWait | output | 1 | Host must hold its request |
| cmdPrecharge | output | 1 | Precharge-all command pulse |
| cmdRefresh | output | 1 | Auto-refresh command pulse |

## Verification
Each result has a fixed delay, counted in cycles from its stimulus. The timer expires on one clock edge and sets the pending request. The precharge-all shows one cycle after the first idle, burst-free cycle that follows. The auto-refresh follows TRP cycles after the precharge. hostWait, irq and statusData[1] follow their inputs within the same cycle. The missed-refresh flag appears one cycle after the late expiry, and it reads 0 one cycle after the read strobe. The bench drives inputs at the falling edge and advances its reference model by one clock per falling edge. It compares every output there, so each result is taken in exactly the cycle its delay puts it in. Directed checks also measure the spacing between refreshes and between the two commands.

// File: rtl/ref_pkg.sv
package ref_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_PRE  = 3'd1,
    SQ_WRP  = 3'd2,
    SQ_REF  = 3'd3,
    SQ_WRF  = 3'd4
  } seqState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic startSeq;  // refresh accepted this cycle
    logic seqBusy;   // sequencer is not idle
  } seqStrobe_t;

endpackage

// File: rtl/ref_ctrl.sv
module ref_ctrl
  import ref_pkg::*;
#(
  parameter int TRFC_W = 4,
  parameter int TRP    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refPending,
  input  logic              hostActive,
  input  logic              hostReq,
  input  logic [TRFC_W-1:0] trfcCfg,
  output seqStrobe_t        strobe,
  output logic              hostWait,
  output logic              cmdPrecharge,
  output logic              cmdRefresh
);

  localparam int TRP_W = $clog2(TRP + 1);
  localparam int SEQ_W = (TRFC_W > TRP_W) ? TRFC_W : TRP_W;
  localparam logic [SEQ_W-1:0] PRE_LOAD = SEQ_W'(TRP - 2);

  seqState_t       seqState;
  logic [SEQ_W-1:0] seqCnt;
  logic             startNow;

  always_comb begin
    startNow        = (seqState == SQ_IDLE) && refPending && !hostActive;
    strobe.startSeq = startNow;
    strobe.seqBusy  = (seqState != SQ_IDLE);
    hostWait        = hostReq && ((seqState != SQ_IDLE) || refPending);
    cmdPrecharge    = (seqState == SQ_PRE);
    cmdRefresh      = (seqState == SQ_REF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqState <= SQ_IDLE;
      seqCnt   <= '0;
    end else begin
      case (seqState)
        SQ_IDLE: if (startNow) seqState <= SQ_PRE;
        SQ_PRE: begin
          seqCnt   <= PRE_LOAD;
          seqState <= SQ_WRP;
        end
        SQ_WRP: begin
          if (seqCnt == '0) seqState <= SQ_REF;
          else              seqCnt   <= seqCnt - 1'b1;
        end
        SQ_REF: begin
          seqCnt   <= SEQ_W'(trfcCfg);
          seqState <= SQ_WRF;
        end
        SQ_WRF: begin
          if (seqCnt <= SEQ_W'(1)) seqState <= SQ_IDLE;
          else                     seqCnt   <= seqCnt - 1'b1;
        end
        default: seqState <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ref_dpath.sv
module ref_dpath
  import ref_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic                statusRd,
  input  logic                irqEn,
  input  seqStrobe_t          strobe,
  output logic                refPending,
  output logic [1:0]          statusData,
  output logic                irq
);

  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] tmr;
  logic                timerOn;
  logic                tick;
  logic                missed;
  logic                errFlag;

  always_comb begin
    timerOn    = (periodCfg != '0);
    tick       = timerOn && (tmr == ONE);
    missed     = tick && refPending && !strobe.startSeq;
    statusData = {refPending || strobe.seqBusy, errFlag};
    irq        = errFlag && irqEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr        <= '0;
      refPending <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      if (!timerOn)                       tmr <= '0;
      else if (tmr == '0 || tmr == ONE)   tmr <= periodCfg;
      else                                tmr <= tmr - 1'b1;
      refPending <= timerOn && (tick || (refPending && !strobe.startSeq));
      errFlag    <= missed || (errFlag && !statusRd);
    end
  end

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched
  import ref_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int TRFC_W   = 4,
  parameter int TRP      = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [TRFC_W-1:0]   trfcCfg,
  input  logic                irqEn,
  input  logic                statusRd,
  output logic [1:0]          statusData,
  output logic                irq,
  input  logic                hostReq,
  input  logic                hostActive,
  output logic                hostWait,
  output logic                cmdPrecharge,
  output logic                cmdRefresh
);

  seqStrobe_t strobe;
  logic       refPending;

  ref_ctrl #(.TRFC_W(TRFC_W), .TRP(TRP)) u_ctrl (
    .clk(clk), .rstN(rstN), .refPending(refPending), .hostActive(hostActive),
    .hostReq(hostReq), .trfcCfg(trfcCfg), .strobe(strobe), .hostWait(hostWait),
    .cmdPrecharge(cmdPrecharge), .cmdRefresh(cmdRefresh)
  );

  ref_dpath #(.PERIOD_W(PERIOD_W)) u_dpath (
    .clk(clk), .rstN(rstN), .periodCfg(periodCfg), .statusRd(statusRd),
    .irqEn(irqEn), .strobe(strobe), .refPending(refPending),
    .statusData(statusData), .irq(irq)
  );

endmodule

// File: rtl/ref_chk.sv
module ref_chk #(
  parameter int TRP = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       cmdPrecharge,
  input logic       cmdRefresh,
  input logic       hostReq,
  input logic       hostWait,
  input logic       hostActive,
  input logic       statusRd,
  input logic [1:0] statusData
);

  localparam int SW = $clog2(TRP + 2) + 1;
  localparam logic [SW-1:0] SAT = SW'(TRP + 1);

  logic [SW-1:0] sincePre;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               sincePre <= '0;
    else if (cmdPrecharge)                   sincePre <= SW'(1);
    else if (sincePre != '0 && sincePre < SAT) sincePre <= sincePre + 1'b1;
  end

  // R3
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdPrecharge && cmdRefresh));

  // R3
  trp_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdRefresh |-> (sincePre == SW'(TRP)));

  // R4
  busy_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && (cmdPrecharge || cmdRefresh)) |-> hostWait);

  // R6
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostActive |=> !cmdPrecharge);

  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusData[0] && !statusRd) |=> statusData[0]);

endmodule

bind sdram_refresh_sched ref_chk #(.TRP(TRP)) u_chk (
  .clk(clk), .rstN(rstN), .cmdPrecharge(cmdPrecharge), .cmdRefresh(cmdRefresh),
  .hostReq(hostReq), .hostWait(hostWait), .hostActive(hostActive),
  .statusRd(statusRd), .statusData(statusData)
);

// File: tb/test_sdram_refresh_sched.sv
module test_sdram_refresh_sched;

  localparam int PW  = 16;
  localparam int TW  = 4;
  localparam int TRP = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [PW-1:0] periodCfg = '0;
  logic [TW-1:0] trfcCfg = '0;
  logic          irqEn = 1'b0;
  logic          statusRd = 1'b0;
  logic [1:0]    statusData;
  logic          irq;
  logic          hostReq = 1'b0;
  logic          hostActive = 1'b0;
  logic          hostWait;
  logic          cmdPrecharge;
  logic          cmdRefresh;

  sdram_refresh_sched #(.PERIOD_W(PW), .TRFC_W(TW), .TRP(TRP)) i_sdram_refresh_sched (
    .clk(clk), .rstN(rstN), .periodCfg(periodCfg), .trfcCfg(trfcCfg),
    .irqEn(irqEn), .statusRd(statusRd), .statusData(statusData), .irq(irq),
    .hostReq(hostReq), .hostActive(hostActive), .hostWait(hostWait),
    .cmdPrecharge(cmdPrecharge), .cmdRefresh(cmdRefresh)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int mTmr = 0, mPend = 0, mErr = 0, mState = 0, mCnt = 0;
  int cyc = 0, lastPre = -1, ivCheck = 0, preCount = 0;
  int burstLeft = 0;
  bit forceActive = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int modelWait();
    return (hostReq && (mState != 0 || mPend != 0)) ? 1 : 0;
  endfunction

  task automatic modelAdvance();
    int p, tick, start, missed, nxtTmr;
    p      = int'(periodCfg);
    tick   = (p != 0 && mTmr == 1) ? 1 : 0;
    start  = (mState == 0 && mPend != 0 && !hostActive) ? 1 : 0;
    missed = (tick != 0 && mPend != 0 && start == 0) ? 1 : 0;
    nxtTmr = (p == 0) ? 0 : ((mTmr <= 1) ? p : mTmr - 1);
    mPend  = (p != 0 && (tick != 0 || (mPend != 0 && start == 0))) ? 1 : 0;
    mErr   = (missed != 0 || (mErr != 0 && !statusRd)) ? 1 : 0;
    mTmr   = nxtTmr;
    case (mState)
      0: if (start != 0) mState = 1;
      1: begin mCnt = TRP - 2; mState = 2; end
      2: if (mCnt == 0) mState = 3; else mCnt--;
      3: begin mCnt = int'(trfcCfg); mState = 4; end
      default: if (mCnt <= 1) mState = 0; else mCnt--;
    endcase
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic step();
    @(negedge clk);
    cyc++;
    if (!rstN) begin
      mTmr = 0; mPend = 0; mErr = 0; mState = 0; mCnt = 0;
    end else begin
      modelAdvance();
    end
    chk(cmdPrecharge == (mState == 1), "R2 cmdPrecharge", int'(cmdPrecharge), int'(mState == 1));
    chk(cmdRefresh == (mState == 3), "R3 cmdRefresh", int'(cmdRefresh), int'(mState == 3));
    chk(int'(hostWait) == modelWait(), "R4/R5 hostWait", int'(hostWait), modelWait());
    chk(int'(statusData[0]) == mErr, "R8/R10 statusData[0]", int'(statusData[0]), mErr);
    chk(int'(statusData[1]) == int'(mPend != 0 || mState != 0), "R11 statusData[1]",
        int'(statusData[1]), int'(mPend != 0 || mState != 0));
    chk(int'(irq) == (mErr & int'(irqEn)), "R9 irq", int'(irq), mErr & int'(irqEn));
    if (cmdRefresh) chk(cyc - lastPre == TRP, "R3 precharge-to-refresh gap", cyc - lastPre, TRP);
    if (cmdPrecharge) begin
      if (ivCheck != 0 && lastPre >= 0)
        chk(cyc - lastPre == int'(periodCfg), "R2 refresh interval", cyc - lastPre, int'(periodCfg));
      lastPre = cyc;
      preCount++;
    end
  endtask

  // host side: decide inputs for the next cycle
  task automatic hostNext(input int reqPct, input int longPct);
    if (hostReq && !hostWait && !hostActive) begin
      burstLeft = 1 + int'($urandom % 8);
      if (int'($urandom % 100) < longPct) burstLeft = 15 + int'($urandom % 20);
      hostReq = 1'b0;
    end else if (burstLeft > 0) begin
      burstLeft--;
    end
    hostActive = forceActive || (burstLeft > 0);
    if (!hostReq && burstLeft == 0 && int'($urandom % 100) < reqPct) hostReq = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = int'($urandom(32'd4242));

    // R1: reset state
    hostReq = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!cmdPrecharge && !cmdRefresh, "R1 commands in reset", int'({cmdPrecharge, cmdRefresh}), 0);
    chk(!hostWait && !irq, "R1 hostWait/irq in reset", int'({hostWait, irq}), 0);
    chk(statusData == 2'b00, "R1 status in reset", int'(statusData), 0);
    hostReq = 1'b0;
    step();
    rstN = 1'b1;

    // R2/R3/R4: steady refresh, no host
    periodCfg = PW'(20); trfcCfg = TW'(4); irqEn = 1'b1;
    ivCheck = 1;
    for (int i = 0; i < 120; i++) step();
    ivCheck = 0;
    chk(preCount >= 5, "R2 refreshes issued", preCount, 5);

    // R5/R6: short host traffic against a 30-cycle period
    periodCfg = PW'(30);
    for (int i = 0; i < 400; i++) begin step(); hostNext(40, 0); end
    while (burstLeft > 0) begin step(); hostNext(0, 0); end
    hostReq = 1'b0;

    // R8: a long burst makes a refresh late
    periodCfg = PW'(10);
    forceActive = 1'b1; hostActive = 1'b1;
    for (int i = 0; i < 25; i++) step();
    chk(statusData[0] == 1'b1, "R8 missed flag set", int'(statusData[0]), 1);
    forceActive = 1'b0; hostActive = 1'b0;
    for (int i = 0; i < 4; i++) step();
    chk(irq == 1'b1, "R9 irq with enable", int'(irq), 1);
    irqEn = 1'b0;
    step();
    chk(irq == 1'b0, "R9 irq masked", int'(irq), 0);
    chk(statusData[0] == 1'b1, "R8 flag stays while masked", int'(statusData[0]), 1);
    statusRd = 1'b1;
    #1;
    chk(statusData[0] == 1'b1, "R10 flag visible during read", int'(statusData[0]), 1);
    step();
    statusRd = 1'b0;
    chk(statusData[0] == 1'b0, "R10 flag cleared after read", int'(statusData[0]), 0);
    irqEn = 1'b1;

    // R7: disabled timer
    periodCfg = '0;
    for (int i = 0; i < 12; i++) step();
    preCount = 0;
    forceActive = 1'b1; hostActive = 1'b1;
    for (int i = 0; i < 150; i++) step();
    forceActive = 1'b0; hostActive = 1'b0;
    chk(preCount == 0, "R7 no refresh when disabled", preCount, 0);
    chk(statusData == 2'b00, "R7 no error when disabled", int'(statusData), 0);

    // random mix of all behaviours
    for (int blk = 0; blk < 10; blk++) begin
      periodCfg = (int'($urandom % 6) == 0) ? '0 : PW'(12 + int'($urandom % 30));
      trfcCfg   = TW'($urandom % 7);
      for (int i = 0; i < 400; i++) begin
        step();
        hostNext(30, 8);
        statusRd = (int'($urandom % 16) == 0);
        if (int'($urandom % 50) == 0) irqEn = ~irqEn;
      end
    end

    statusRd = 1'b0;
    step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule